// File: doc/BRIEF.md
# Dual-Phase Piezo Drive PWM Generator

This block produces two related pulse-width-modulated drive waveforms, channel A and channel B, for a piezo focus actuator. A prescaler turns a source of events into a base time unit. The source is either every cycle of the block clock or each synchronized rising edge of an external reference input. A position counter walks through one drive period in those units. Each channel owns two transition positions inside the period. At its "on" position the channel leaves its polarity level. At its "off" position it returns to that level. Together these two positions set the duty of each channel and the phase offset between the two channels.

Software programs the block through a simple parallel write port and then issues a one-cycle start pulse. The move then runs for a programmed number of whole periods, raises a one-cycle done pulse and stops. A direction bit exchanges the timing of the two channels, so the motor reverses without any change to the timing values. Each channel has an enable bit, a polarity bit and a selectable idle state: high impedance, driven low or driven high. The idle state is presented as an output-enable plus a level. All timing and control values are copied when a move is accepted.

Top module: `pdrv_dual_pwm`

## Requirements
- R1: After reset `busy`, `done`, `oe_a`, `out_a`, `oe_b` and `out_b` are all 0, and every register holds 0.
- R2: One base unit lasts DIV+1 source events, where DIV is the value at address 1. With reference select 0, a source event is every clock cycle.
- R3: A move is accepted at the clock edge where `start` is 1. From the next cycle, an enabled channel drives `oe`=1 and its level. For unit u, with position p = u mod PERIOD:
  - At the start of the move the level is the channel's polarity bit.
  - The level becomes the polarity at p = off.
  - Otherwise the level becomes the inverted polarity at p = on.
  - Otherwise the level holds, including across period boundaries.
  - When on equals off, off takes priority.
- R4: An on or off position greater than or equal to PERIOD never fires.
- R5: A move lasts PERIOD×STEPS base units, with PERIOD at address 2 and STEPS at address 3. `busy` is 1 from the cycle after acceptance to the end of the move. In the cycle after the last unit, `busy` is 0 and `done` is 1 for exactly one cycle.
- R6: With the direction bit (control bit 4) set, channel A uses B's on/off values (addresses 6/7) and channel B uses A's values (addresses 4/5). Enables and polarities stay with their channels.
- R7: The idle code is control bits [7:6] for A and [9:8] for B:
  - 00 and 11 give high impedance (`oe`=0, `out`=0).
  - 01 gives low (`oe`=1, `out`=0).
  - 10 gives high (`oe`=1, `out`=1).
  - A channel shows its idle code while no move runs, and during a move if its enable bit (control bit 0 for A, 1 for B) is 0.
- R8: `start` is ignored while `busy` is 1, and also when PERIOD or STEPS is 0.
- R9: Register writes made during a move do not alter that move. They take effect on the next accepted move.
- R10: With reference select (control bit 5) set, source events are the rising edges of `ext_ref`, passed through a two-flop synchronizer. Without such edges a move makes no progress.
- R11: The write address map is:
  - 0: control
  - 1: DIV
  - 2: PERIOD
  - 3: STEPS
  - 4: A on
  - 5: A off
  - 6: B on
  - 7: B off
  - Control bits 2 and 3 are the polarities of A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| start | input | 1 | One-cycle move request |
| ext_ref | input | 1 | External reference, asynchronous |
| out_a | output | 1 | Channel A level |
| oe_a | output | 1 | Channel A output enable (0 = high impedance) |
| out_b | output | 1 | Channel B level |
| oe_b | output | 1 | Channel B output enable (0 = high impedance) |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle pulse at move completion |

## Verification
The hardest case to reach is a register write and a second start pulse arriving in the middle of a running move. Both must leave that move untouched while the written value still reaches the next move. The bench writes a new PERIOD and raises `start` on the second and third cycles of a move. It compares that move cycle by cycle against the old configuration, then launches a move without reprogramming and expects the new PERIOD. The sweep covers every pair of on/off positions from 0 up to PERIOD, for PERIOD 1 to 4. This includes ties and positions that never fire. The external reference path is driven by an exact count of pulses, so the end of the move is known to the pulse.

// File: rtl/pdrv_pkg.sv
package pdrv_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STEPS = 3'd3;
  localparam logic [ADDR_W-1:0] A_TON0  = 3'd4;

  typedef enum logic [1:0] {
    IDLE_HIZ  = 2'b00,
    IDLE_LOW  = 2'b01,
    IDLE_HIGH = 2'b10,
    IDLE_HIZ2 = 2'b11
  } idle_e;

  typedef struct packed {
    logic [1:0] idle_b;
    logic [1:0] idle_a;
    logic       ref_sel;
    logic       dir;
    logic       pol_b;
    logic       pol_a;
    logic       en_b;
    logic       en_a;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pdrv_regs.sv
module pdrv_regs
  import pdrv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8,
  parameter int PER_W  = 8,
  parameter int STEP_W = 12,
  parameter int NCH    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output ctrl_t                     ctrl,
  output logic [PRE_W-1:0]          div,
  output logic [PER_W-1:0]          per,
  output logic [STEP_W-1:0]         steps,
  output logic [NCH-1:0][PER_W-1:0] t_on,
  output logic [NCH-1:0][PER_W-1:0] t_off
);

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      div   <= '0;
      per   <= '0;
      steps <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_DIV:   div   <= wr_data[PRE_W-1:0];
        A_PER:   per   <= wr_data[PER_W-1:0];
        A_STEPS: steps <= wr_data[STEP_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_tim
    localparam logic [ADDR_W-1:0] AON  = A_TON0 + ADDR_W'(2 * ch);
    localparam logic [ADDR_W-1:0] AOFF = A_TON0 + ADDR_W'(2 * ch + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        t_on[ch]  <= '0;
        t_off[ch] <= '0;
      end else if (wr_en) begin
        if (wr_addr == AON)  t_on[ch]  <= wr_data[PER_W-1:0];
        if (wr_addr == AOFF) t_off[ch] <= wr_data[PER_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pdrv_timebase.sv
module pdrv_timebase #(
  parameter int PRE_W  = 8,
  parameter int PER_W  = 8,
  parameter int STEP_W = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ref_sel,
  input  logic              ext_ref,
  input  logic [PRE_W-1:0]  div,
  input  logic [PER_W-1:0]  per,
  input  logic [STEP_W-1:0] steps,
  output logic              load,
  output logic              adv,
  output logic              busy_n,
  output logic [PER_W-1:0]  pos_n,
  output logic              busy,
  output logic              done
);

  localparam int SY_W = SYNC_N + 1;

  logic [SY_W-1:0]   sy;
  logic              evt_ext, src_evt, tick, end_per, last;
  logic [PRE_W-1:0]  pre_cnt, div_s;
  logic [PER_W-1:0]  pos, per_s;
  logic [STEP_W-1:0] stp, stp_s;
  logic              rsel_s;

  always_ff @(posedge clk) begin
    if (rst) sy <= '0;
    else     sy <= {sy[SY_W-2:0], ext_ref};
  end

  assign evt_ext = sy[SY_W-2] & ~sy[SY_W-1];
  assign load    = start & ~busy & (per != '0) & (steps != '0);
  assign src_evt = rsel_s ? evt_ext : 1'b1;
  assign tick    = busy & src_evt & (pre_cnt == div_s);
  assign end_per = (pos == per_s - 1'b1);
  assign last    = tick & end_per & (stp == stp_s - 1'b1);
  assign adv     = tick & ~last;
  assign busy_n  = load | (busy & ~last);
  assign pos_n   = (load | end_per) ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      pre_cnt <= '0;
      pos     <= '0;
      stp     <= '0;
      div_s   <= '0;
      per_s   <= '0;
      stp_s   <= '0;
      rsel_s  <= 1'b0;
    end else begin
      busy <= busy_n;
      done <= last;
      if (load) begin
        div_s   <= div;
        per_s   <= per;
        stp_s   <= steps;
        rsel_s  <= ref_sel;
        pre_cnt <= '0;
        pos     <= '0;
        stp     <= '0;
      end else if (busy && src_evt) begin
        if (pre_cnt == div_s) begin
          pre_cnt <= '0;
          pos     <= pos_n;
          if (end_per) stp <= stp + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pdrv_chan.sv
module pdrv_chan
  import pdrv_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic             busy_n,
  input  logic [PER_W-1:0] pos_n,
  input  logic [PER_W-1:0] t_on,
  input  logic [PER_W-1:0] t_off,
  input  logic             pol,
  input  logic             en,
  input  idle_e            idle,
  output logic             out,
  output logic             oe
);

  logic [PER_W-1:0] ton_s, toff_s;
  logic             pol_s, en_s, lvl, lvl_n, run, en_e;
  idle_e            idle_s, idle_e_sel;

  function automatic logic step_lvl(input logic cur, input logic p,
                                    input logic [PER_W-1:0] ps,
                                    input logic [PER_W-1:0] on,
                                    input logic [PER_W-1:0] off);
    if (ps == off)     return p;
    else if (ps == on) return ~p;
    else               return cur;
  endfunction

  always_comb begin
    if (load)     lvl_n = step_lvl(pol, pol, '0, t_on, t_off);
    else if (adv) lvl_n = step_lvl(lvl, pol_s, pos_n, ton_s, toff_s);
    else          lvl_n = lvl;
    en_e       = load ? en : en_s;
    idle_e_sel = busy_n ? (load ? idle : idle_s) : idle;
    run        = busy_n & en_e;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ton_s  <= '0;
      toff_s <= '0;
      pol_s  <= 1'b0;
      en_s   <= 1'b0;
      idle_s <= IDLE_HIZ;
      lvl    <= 1'b0;
      out    <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (load) begin
        ton_s  <= t_on;
        toff_s <= t_off;
        pol_s  <= pol;
        en_s   <= en;
        idle_s <= idle;
      end
      lvl <= lvl_n;
      out <= run ? lvl_n : (idle_e_sel == IDLE_HIGH);
      oe  <= run | (idle_e_sel == IDLE_LOW) | (idle_e_sel == IDLE_HIGH);
    end
  end

endmodule

// File: rtl/pdrv_dual_pwm.sv
module pdrv_dual_pwm
  import pdrv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8,
  parameter int PER_W  = 8,
  parameter int STEP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic              ext_ref,
  output logic              out_a,
  output logic              oe_a,
  output logic              out_b,
  output logic              oe_b,
  output logic              busy,
  output logic              done
);

  localparam int NCH = 2;

  ctrl_t                     ctrl;
  logic [PRE_W-1:0]          div;
  logic [PER_W-1:0]          per, pos_n;
  logic [STEP_W-1:0]         steps;
  logic [NCH-1:0][PER_W-1:0] t_on, t_off;
  logic                      load, adv, busy_n;
  logic [NCH-1:0]            en_v, pol_v, out_v, oe_v;
  idle_e                     idle_v [NCH];

  pdrv_regs #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .PER_W(PER_W), .STEP_W(STEP_W), .NCH(NCH)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .div(div), .per(per), .steps(steps), .t_on(t_on), .t_off(t_off)
  );

  pdrv_timebase #(
    .PRE_W(PRE_W), .PER_W(PER_W), .STEP_W(STEP_W), .SYNC_N(2)
  ) u_tb (
    .clk(clk), .rst(rst), .start(start), .ref_sel(ctrl.ref_sel),
    .ext_ref(ext_ref), .div(div), .per(per), .steps(steps),
    .load(load), .adv(adv), .busy_n(busy_n), .pos_n(pos_n),
    .busy(busy), .done(done)
  );

  assign en_v      = {ctrl.en_b, ctrl.en_a};
  assign pol_v     = {ctrl.pol_b, ctrl.pol_a};
  assign idle_v[0] = idle_e'(ctrl.idle_a);
  assign idle_v[1] = idle_e'(ctrl.idle_b);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int OTHER = NCH - 1 - ch;
    logic [PER_W-1:0] on_sel, off_sel;
    assign on_sel  = ctrl.dir ? t_on[OTHER]  : t_on[ch];
    assign off_sel = ctrl.dir ? t_off[OTHER] : t_off[ch];

    pdrv_chan #(.PER_W(PER_W)) u_ch (
      .clk(clk), .rst(rst), .load(load), .adv(adv), .busy_n(busy_n),
      .pos_n(pos_n), .t_on(on_sel), .t_off(off_sel), .pol(pol_v[ch]),
      .en(en_v[ch]), .idle(idle_v[ch]), .out(out_v[ch]), .oe(oe_v[ch])
    );
  end

  assign out_a = out_v[0];
  assign oe_a  = oe_v[0];
  assign out_b = out_v[1];
  assign oe_b  = oe_v[1];

endmodule

// File: rtl/pdrv_chk.sv
module pdrv_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic out_a,
  input logic oe_a,
  input logic out_b,
  input logic oe_b
);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fall_gives_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_hiz_level_a_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_a |-> !out_a);

  assert_hiz_level_b_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_b |-> !out_b);

endmodule

bind pdrv_dual_pwm pdrv_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .out_a(out_a), .oe_a(oe_a), .out_b(out_b), .oe_b(oe_b)
);

// File: tb/tb_pdrv_dual_pwm.sv
`timescale 1ns/1ps
module tb_pdrv_dual_pwm;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic        ext_ref = 1'b0;
  logic        out_a, oe_a, out_b, oe_b, busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;

  int m_div, m_per, m_steps, m_ctrl;
  int m_on [2];
  int m_off[2];

  always #2 clk = ~clk;

  pdrv_dual_pwm dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .ext_ref(ext_ref), .out_a(out_a), .oe_a(oe_a),
    .out_b(out_b), .oe_b(oe_b), .busy(busy), .done(done)
  );

  always @(negedge clk) if (!rst && done) done_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mk_ctrl(int ena, int enb, int pa, int pb, int dir,
                                 int rsel, int ia, int ib);
    return ena | (enb << 1) | (pa << 2) | (pb << 3) | (dir << 4) |
           (rsel << 5) | (ia << 6) | (ib << 8);
  endfunction

  function automatic bit nxt(bit cur, bit p, int pos, int on, int off);
    if (pos == off) return p;
    if (pos == on)  return ~p;
    return cur;
  endfunction

  function automatic bit [1:0] idl(int code);
    return {(code == 1) || (code == 2), code == 2};
  endfunction

  function automatic logic [5:0] got();
    return {busy, done, oe_a, out_a, oe_b, out_b};
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(int dv, int pr, int st, int aon, int aoff, int bon,
                      int boff, int ct);
    wr(1, dv); wr(2, pr); wr(3, st);
    wr(4, aon); wr(5, aoff); wr(6, bon); wr(7, boff); wr(0, ct);
    m_div = dv; m_per = pr; m_steps = st; m_ctrl = ct;
    m_on[0] = aon; m_off[0] = aoff; m_on[1] = bon; m_off[1] = boff;
  endtask

  function automatic logic [5:0] idle_vec(bit b, bit d);
    bit [1:0] ia, ib;
    ia = idl((m_ctrl >> 6) & 3);
    ib = idl((m_ctrl >> 8) & 3);
    return {b, d, ia, ib};
  endfunction

  task automatic run_check(input string req, input bit poke);
    bit   lv [2];
    bit   en [2];
    int   t1 [2];
    int   t2 [2];
    int   c, dir;
    logic [5:0] e;
    bit   [1:0] ia, ib;
    dir = (m_ctrl >> 4) & 1;
    for (int ch = 0; ch < 2; ch++) begin
      en[ch] = (m_ctrl >> ch) & 1;
      lv[ch] = (m_ctrl >> (2 + ch)) & 1;
      t1[ch] = dir ? m_on[1-ch]  : m_on[ch];
      t2[ch] = dir ? m_off[1-ch] : m_off[ch];
    end
    ia = idl((m_ctrl >> 6) & 3);
    ib = idl((m_ctrl >> 8) & 3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    for (int u = 0; u < m_per * m_steps; u++) begin
      for (int ch = 0; ch < 2; ch++)
        lv[ch] = nxt(lv[ch], (m_ctrl >> (2 + ch)) & 1, u % m_per, t1[ch], t2[ch]);
      for (int k = 0; k <= m_div; k++) begin
        e = {1'b1, 1'b0, en[0] ? {1'b1, lv[0]} : ia, en[1] ? {1'b1, lv[1]} : ib};
        chk(got() === e, req, got(), e);
        if (poke && c == 1) begin
          wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'(m_per + 2); start = 1'b1;
        end
        if (poke && c == 2) begin
          wr_en = 1'b0; start = 1'b0;
        end
        @(negedge clk);
        c++;
      end
    end
    e = idle_vec(1'b0, 1'b1);
    chk(got() === e, "R5 end", got(), e);
    @(negedge clk);
    e = idle_vec(1'b0, 1'b0);
    chk(got() === e, "R5 after", got(), e);
    if (poke) m_per = m_per + 2;
  endtask

  task automatic pulse_ext();
    ext_ref = 1'b1;
    repeat (2) @(negedge clk);
    ext_ref = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(got() === 6'b0, "R1", got(), 0);

    // R7: idle codes while no move runs
    for (int code = 0; code < 4; code++) begin
      m_ctrl = mk_ctrl(1, 1, 0, 0, 0, 0, code, 3 - code);
      wr(0, m_ctrl);
      repeat (2) @(negedge clk);
      chk(got() === idle_vec(1'b0, 1'b0), "R7 idle", got(), idle_vec(1'b0, 1'b0));
    end

    // R3/R4 near-exhaustive sweep over on/off positions (R11 map)
    for (int pr = 1; pr <= 4; pr++)
      for (int on = 0; on <= pr; on++)
        for (int off = 0; off <= pr; off++) begin
          prog((on + off) % 3, pr, 1 + (on % 2), on, off, (off + 1) % (pr + 1), on,
               mk_ctrl(1, 1, on & 1, (off & 1) ^ 1, 0, 0, 1, 2));
          run_check((on >= pr || off >= pr) ? "R4" : "R3", 1'b0);
        end

    // R2: longer base unit
    prog(3, 3, 2, 0, 2, 1, 0, mk_ctrl(1, 1, 0, 1, 0, 0, 0, 0));
    run_check("R2", 1'b0);

    // R6: direction swap with asymmetric timing
    prog(1, 4, 2, 1, 3, 2, 0, mk_ctrl(1, 1, 0, 0, 1, 0, 0, 0));
    run_check("R6", 1'b0);

    // R7: disabled channel shows its idle code during a move
    for (int code = 0; code < 4; code++) begin
      prog(0, 3, 1, 0, 2, 1, 2, mk_ctrl(code & 1, (code >> 1) ^ 1, 1, 0, 0, 0, code, 3 - code));
      run_check("R7 move", 1'b0);
    end

    // R9 and R8: write PERIOD and pulse start mid-move
    prog(1, 3, 2, 0, 1, 2, 0, mk_ctrl(1, 1, 0, 1, 0, 0, 1, 1));
    run_check("R9 R8", 1'b1);
    run_check("R9 next", 1'b0);

    // R5: several step counts
    for (int st = 1; st <= 3; st++) begin
      prog(0, 2, st, 0, 1, 1, 0, mk_ctrl(1, 1, 0, 0, 0, 0, 2, 2));
      run_check("R5", 1'b0);
    end

    // R8: PERIOD = 0 and STEPS = 0 ignore start
    prog(0, 0, 3, 0, 1, 0, 1, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    d0 = done_cnt;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done_cnt == d0, "R8 per0", busy, 0);
    prog(0, 3, 0, 0, 1, 0, 1, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done_cnt == d0, "R8 steps0", busy, 0);

    // R10: external reference, DIV=1 PERIOD=2 STEPS=1 needs 4 edges
    prog(1, 2, 1, 0, 1, 1, 0, mk_ctrl(1, 1, 0, 0, 0, 1, 0, 0));
    d0 = done_cnt;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy === 1'b1, "R10 stall", busy, 1);
    for (int p = 0; p < 3; p++) pulse_ext();
    chk(busy === 1'b1, "R10 three", busy, 1);
    pulse_ext();
    chk(busy === 1'b0 && done_cnt == d0 + 1, "R10 four", {busy, 4'(done_cnt - d0)}, 1);

    summary();
    $finish;
  end

endmodule